// File: doc/BRIEF.md
# Tiny 8-bit four-register processor

This block is a small multi-cycle processor core. It holds four 8-bit general registers, an 8-bit program counter and a 256-byte unified memory. Instructions are one byte long. Some are followed by an immediate byte. The core steps each instruction through a fixed sequence of states: fetch, decode, an optional immediate read, an optional data access, and writeback. It executes register moves, AND, add, a group of unary operations, loads, stores, immediate forms and a signed conditional jump.

The memory is filled before the core runs. While reset is held low, a testbench drives the load port one byte per clock. After reset is released, the core executes from address 0. It shows its register file, program counter and a halted flag, so a bench can watch progress and detect the end of a program.

Top module: `tiny8_core`

## Requirements
- R1: While reset is low, the PC and all four registers are cleared to 0 and `halted` is 0. These values are visible on the first cycle after release.
- R2: An instruction byte with bit 7 set changes no register and no memory byte. The PC stays on that instruction for good, and `halted` goes to 1 and stays there. For example, `00 00 00 80` settles with PC 3.
- R3: Instruction byte fields are: bits 6:4 = icode, bits 3:2 = a, bits 1:0 = b. icode 0 sets rA = rB, icode 1 sets rA = rA AND rB, and icode 2 sets rA = (rA + rB) mod 256. Each of these advances the PC by 1.
- R4: icode 3 chooses an operation by b. b=0 gives the bitwise complement of rA. b=1 gives 1 when rA is 0 and 0 otherwise. b=2 gives 0 - rA mod 256. b=3 gives the address of the current instruction. Each advances the PC by 1.
- R5: icode 4 loads rA from the memory byte at address rB. icode 5 stores rA to the memory byte at address rB. Both advance the PC by 1.
- R6: icode 6 reads the immediate byte at PC+1. b=0 loads it into rA, b=1 ANDs it into rA, b=2 adds it to rA, and b=3 loads rA from memory at the address the immediate gives. The PC advances by 2 in all four cases.
- R7: icode 7 reads rA as a signed byte. When rA is 0 or has bit 7 set, the next PC is rB. Otherwise the PC advances by 1. No register changes.
- R8: All PC arithmetic wraps modulo 256. This covers the immediate read at PC+1 and the PC+2 step.
- R9: Each clock with `load_en` high writes `load_data` into memory at `load_addr`. The program sees those bytes.
- R10: `halted` is 0 while a program made only of instructions with bit 7 clear is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Memory preload strobe |
| load_addr | input | 8 | Preload byte address |
| load_data | input | 8 | Preload byte value |
| reg_view | output | 32 | Register file; register i at bits 8*i+7:8*i |
| pc_view | output | 8 | Current program counter |
| halted | output | 1 | Decoded instruction has bit 7 set |

## Verification
The bench aims at the places where a plausible wrong design would diverge from a correct one:
- **Signed jump test.** rA is set to 0x00, 0x80, 0xF6, 0x7F and 0x0A. An unsigned compare would fall through on the negative values.
- **Immediate forms.** A core that stepped the PC by 1 after an immediate-form instruction would execute the immediate as an opcode, and the final register values would be wrong.
- **Unary operations.** Both outcomes of the logical-not are tested, and so is PC capture. Capture must return the instruction's own address, not the next address.
- **PC wrap-around.** A jump to 0xFF is followed by an immediate instruction, so the operand read must wrap to address 0. The next PC must also wrap, to 1.
- **Halt freeze.** After a halt, the bench checks that the PC and registers stay frozen. A design that kept stepping would move past the halt byte.

// File: rtl/tiny8_pkg.sv
package tiny8_pkg;
  localparam int XLEN    = 8;
  localparam int REG_CNT = 4;
  localparam int IDX_W   = $clog2(REG_CNT);
  localparam int MEM_AW  = XLEN;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_IMM, ST_MEM, ST_WB
  } state_t;

  localparam logic [2:0] OP_MOV   = 3'd0;
  localparam logic [2:0] OP_AND   = 3'd1;
  localparam logic [2:0] OP_ADD   = 3'd2;
  localparam logic [2:0] OP_UNARY = 3'd3;
  localparam logic [2:0] OP_LOAD  = 3'd4;
  localparam logic [2:0] OP_STORE = 3'd5;
  localparam logic [2:0] OP_IMM   = 3'd6;
  localparam logic [2:0] OP_JLE   = 3'd7;

  // signed "less than or equal to zero"
  function automatic logic is_le_zero(input logic [XLEN-1:0] v);
    return (v == '0) || v[XLEN-1];
  endfunction

  function automatic logic writes_reg(input logic [2:0] op);
    return (op != OP_STORE) && (op != OP_JLE);
  endfunction

  function automatic logic [XLEN-1:0] calc_result(
    input logic [2:0]      op,
    input logic [1:0]      sub,
    input logic [XLEN-1:0] ra,
    input logic [XLEN-1:0] rb,
    input logic [XLEN-1:0] imm,
    input logic [XLEN-1:0] mdata,
    input logic [XLEN-1:0] pc
  );
    logic [XLEN-1:0] r;
    case (op)
      OP_MOV:   r = rb;
      OP_AND:   r = ra & rb;
      OP_ADD:   r = ra + rb;
      OP_UNARY: begin
        case (sub)
          2'd0:    r = ~ra;
          2'd1:    r = {{(XLEN-1){1'b0}}, (ra == '0)};
          2'd2:    r = '0 - ra;
          default: r = pc;
        endcase
      end
      OP_LOAD:  r = mdata;
      OP_IMM: begin
        case (sub)
          2'd0:    r = imm;
          2'd1:    r = ra & imm;
          2'd2:    r = ra + imm;
          default: r = mdata;
        endcase
      end
      default:  r = ra;
    endcase
    return r;
  endfunction

  function automatic logic [XLEN-1:0] calc_next_pc(
    input logic [2:0]      op,
    input logic [XLEN-1:0] ra,
    input logic [XLEN-1:0] rb,
    input logic [XLEN-1:0] pc
  );
    if (op == OP_IMM)                    return pc + XLEN'(2);
    else if (op == OP_JLE && is_le_zero(ra)) return rb;
    else                                 return pc + XLEN'(1);
  endfunction
endpackage

// File: rtl/tiny8_ram.sv
module tiny8_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // single port, registered read, one access per cycle
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/tiny8_regfile.sv
module tiny8_regfile #(
  parameter int DW = 8,
  parameter int N  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [$clog2(N)-1:0] widx,
  input  logic [DW-1:0]        wdata,
  input  logic [$clog2(N)-1:0] idx_a,
  input  logic [$clog2(N)-1:0] idx_b,
  output logic [DW-1:0]        val_a,
  output logic [DW-1:0]        val_b,
  output logic [N*DW-1:0]      view
);
  logic [DW-1:0] regs [N];

  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                    regs[g] <= '0;
      else if (we && widx == g[$clog2(N)-1:0]) regs[g] <= wdata;
    end
    assign view[g*DW +: DW] = regs[g];
  end

  assign val_a = regs[idx_a];
  assign val_b = regs[idx_b];

  assert_regs_hold_without_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(view));
endmodule

// File: rtl/tiny8_core.sv
module tiny8_core
  import tiny8_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_en,
  input  logic [MEM_AW-1:0]     load_addr,
  input  logic [XLEN-1:0]       load_data,
  output logic [REG_CNT*XLEN-1:0] reg_view,
  output logic [XLEN-1:0]       pc_view,
  output logic                  halted
);
  state_t          state_q, state_d;
  logic [XLEN-1:0] pc_q, ir_q, imm_q;
  logic [XLEN-1:0] mem_rdata, ra_val, rb_val;
  logic [MEM_AW-1:0] core_addr;
  logic            core_we;

  // instruction fields of the held instruction
  logic [2:0]       op;
  logic [IDX_W-1:0] fa, fb;
  assign op = ir_q[6:4];
  assign fa = ir_q[3:2];
  assign fb = ir_q[1:0];

  // named events for the checks
  logic halt_hit, wb_fire, reg_we;
  logic [XLEN-1:0] wb_value, pc_next;
  assign halt_hit = (state_q == ST_DECODE) && mem_rdata[XLEN-1];
  assign wb_fire  = (state_q == ST_WB);
  assign reg_we   = wb_fire && writes_reg(op);
  assign wb_value = calc_result(op, fb, ra_val, rb_val, imm_q, mem_rdata, pc_q);
  assign pc_next  = calc_next_pc(op, ra_val, rb_val, pc_q);

  always_comb begin
    state_d   = state_q;
    core_addr = pc_q;
    core_we   = 1'b0;
    case (state_q)
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: begin
        core_addr = pc_q + XLEN'(1);  // immediate read issued early
        if (mem_rdata[XLEN-1])           state_d = ST_FETCH;
        else if (mem_rdata[6:4] == OP_IMM) state_d = ST_IMM;
        else if (mem_rdata[6:4] == OP_LOAD || mem_rdata[6:4] == OP_STORE) state_d = ST_MEM;
        else                             state_d = ST_WB;
      end
      ST_IMM:    state_d = (fb == 2'd3) ? ST_MEM : ST_WB;
      ST_MEM: begin
        core_addr = (op == OP_IMM) ? imm_q : rb_val;
        core_we   = (op == OP_STORE);
        state_d   = ST_WB;
      end
      default:   state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
      pc_q    <= '0;
      ir_q    <= '0;
      imm_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_DECODE) ir_q  <= mem_rdata;
      if (state_q == ST_IMM)    imm_q <= mem_rdata;
      if (wb_fire)              pc_q  <= pc_next;
    end
  end

  tiny8_ram #(.AW(MEM_AW), .DW(XLEN)) i_ram (
    .clk   (clk),
    .we    (load_en | core_we),
    .addr  (load_en ? load_addr : core_addr),
    .wdata (load_en ? load_data : ra_val),
    .rdata (mem_rdata)
  );

  tiny8_regfile #(.DW(XLEN), .N(REG_CNT)) i_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (reg_we),
    .widx  (fa),
    .wdata (wb_value),
    .idx_a (fa),
    .idx_b (fb),
    .val_a (ra_val),
    .val_b (rb_val),
    .view  (reg_view)
  );

  assign pc_view = pc_q;
  assign halted  = ir_q[XLEN-1];

  assert_halt_pc_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    halt_hit |=> (pc_q == $past(pc_q)) && (state_q == ST_FETCH));
  assert_halted_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !load_en) |=> halted && $stable(pc_q));
  assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_fire && op <= OP_STORE) |=> pc_q == $past(pc_q) + XLEN'(1));
  assert_imm_step_two_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_fire && op == OP_IMM) |=> pc_q == $past(pc_q) + XLEN'(2));
  assert_jump_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_fire && op == OP_JLE && (ra_val == '0 || ra_val[XLEN-1])) |=> pc_q == $past(rb_val));
endmodule

// File: tb/test_tiny8_core.sv
`timescale 1ns/1ps
module test_tiny8_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_en = 1'b0;
  logic [7:0]  load_addr = '0;
  logic [7:0]  load_data = '0;
  logic [31:0] reg_view;
  logic [7:0]  pc_view;
  logic        halted;

  int checks = 0;
  int failures = 0;
  logic [7:0] prog [256];

  always #2.5 clk = ~clk;

  tiny8_core i_tiny8_core (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
    .load_data(load_data), .reg_view(reg_view), .pc_view(pc_view), .halted(halted)
  );

  function automatic logic [7:0] rg(input int i);
    return reg_view[8*i +: 8];
  endfunction

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 256; i++) prog[i] = 8'h80;
  endtask

  // holds reset, preloads memory through the load port (R9), releases reset
  task automatic load_and_start();
    rst_n = 1'b0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      load_en = 1'b1; load_addr = 8'(i); load_data = prog[i];
    end
    @(negedge clk);
    load_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_to_halt(input string tag);
    int n = 0;
    while (!halted && n < 2000) begin
      @(negedge clk);
      n++;
    end
    checks++;
    if (!halted) begin
      failures++;
      $display("FAIL %s no halt actual=0 expected=1", tag);
    end
  endtask

  task automatic check_regs(input string tag, input logic [7:0] e0, e1, e2, e3, epc);
    check8({tag, " r0"}, rg(0), e0);
    check8({tag, " r1"}, rg(1), e1);
    check8({tag, " r2"}, rg(2), e2);
    check8({tag, " r3"}, rg(3), e3);
    check8({tag, " pc"}, pc_view, epc);
  endtask

  task automatic t_reset_r1();
    clear_prog();
    load_and_start();
    check_regs("R1 reset", 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    check8("R1 halted at reset", {7'd0, halted}, 8'h00);
  endtask

  task automatic t_halt_r2();
    clear_prog();
    prog[0] = 8'h00; prog[1] = 8'h00; prog[2] = 8'h00; prog[3] = 8'h80;
    load_and_start();
    run_to_halt("R2 halt");
    check_regs("R2 halt", 8'h00, 8'h00, 8'h00, 8'h00, 8'h03);
    // halt byte carrying other fields must still do nothing
    clear_prog();
    prog[0] = 8'h64; prog[1] = 8'h33; prog[2] = 8'hF5;
    load_and_start();
    run_to_halt("R2 halt payload");
    repeat (12) @(negedge clk);
    check_regs("R2 frozen", 8'h00, 8'h33, 8'h00, 8'h00, 8'h02);
    check8("R2 halted sticky", {7'd0, halted}, 8'h01);
  endtask

  task automatic t_alu_r3();
    clear_prog();
    prog[0] = 8'h64; prog[1] = 8'hF0; prog[2] = 8'h68; prog[3] = 8'h30;
    prog[4] = 8'h0D; prog[5] = 8'h19; prog[6] = 8'h26; prog[7] = 8'h80;
    load_and_start();
    repeat (4) @(negedge clk);
    check8("R10 halted low while running", {7'd0, halted}, 8'h00);
    run_to_halt("R3 alu");
    check_regs("R3 alu", 8'h00, 8'h20, 8'h30, 8'hF0, 8'h07);
  endtask

  task automatic t_unary_r4();
    clear_prog();
    prog[0] = 8'h64; prog[1] = 8'h89; prog[2] = 8'h34;
    prog[3] = 8'h39;
    prog[4] = 8'h60; prog[5] = 8'h05; prog[6] = 8'h32;
    prog[7] = 8'h3F; prog[8] = 8'h80;
    load_and_start();
    run_to_halt("R4 unary");
    check_regs("R4 unary", 8'hFB, 8'h76, 8'h01, 8'h07, 8'h08);
    clear_prog();
    prog[0] = 8'h68; prog[1] = 8'h07; prog[2] = 8'h39; prog[3] = 8'h80;
    load_and_start();
    run_to_halt("R4 lnot nonzero");
    check8("R4 lnot nonzero r2", rg(2), 8'h00);
  endtask

  task automatic t_mem_r5();
    clear_prog();
    prog[0] = 8'h68; prog[1] = 8'h23; prog[2] = 8'h06; prog[3] = 8'h60;
    prog[4] = 8'h20; prog[5] = 8'h54; prog[6] = 8'h80;
    load_and_start();
    run_to_halt("R5 move");
    check_regs("R5 move", 8'h20, 8'h23, 8'h23, 8'h00, 8'h06);
    prog[6] = 8'h4C; prog[7] = 8'h80;  // read stored byte back into r3
    load_and_start();
    run_to_halt("R5 store/load");
    check_regs("R5 store/load", 8'h20, 8'h23, 8'h23, 8'h23, 8'h07);
  endtask

  task automatic t_imm_r6();
    clear_prog();
    prog[0] = 8'h64; prog[1] = 8'h14; prog[2] = 8'h65; prog[3] = 8'h24;
    prog[4] = 8'h66; prog[5] = 8'hFE; prog[6] = 8'h6B; prog[7] = 8'h00;
    prog[8] = 8'h80;
    load_and_start();
    run_to_halt("R6 imm");
    // r2 = byte 0x64 preloaded at address 0 (R9)
    check_regs("R6 R9 imm", 8'h00, 8'h02, 8'h64, 8'h00, 8'h08);
  endtask

  task automatic jump_case(input logic [7:0] v, input logic taken);
    clear_prog();
    prog[0] = 8'h60; prog[1] = v; prog[2] = 8'h64; prog[3] = 8'h14;
    prog[4] = 8'h71; prog[5] = 8'h80; prog[8'h14] = 8'h80;
    load_and_start();
    run_to_halt("R7 jump");
    check_regs($sformatf("R7 jump rA=%02h", v), v, 8'h14, 8'h00, 8'h00, taken ? 8'h14 : 8'h05);
  endtask

  task automatic t_jump_r7();
    jump_case(8'hF6, 1'b1);
    jump_case(8'h00, 1'b1);
    jump_case(8'h80, 1'b1);
    jump_case(8'h7F, 1'b0);
    jump_case(8'h0A, 1'b0);
  endtask

  task automatic t_wrap_r8();
    clear_prog();
    prog[0] = 8'h64; prog[1] = 8'hFF; prog[2] = 8'h71;
    prog[8'hFF] = 8'h68;  // immediate comes from address 0
    load_and_start();
    run_to_halt("R8 wrap");
    check_regs("R8 wrap", 8'h00, 8'hFF, 8'h64, 8'h00, 8'h01);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset_r1();
    t_halt_r2();
    t_alu_r3();
    t_unary_r4();
    t_mem_r5();
    t_imm_r6();
    t_jump_r7();
    t_wrap_r8();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule